// File: doc/BRIEF.md
# Hysteresis Stop/Go Flow Control for a Phit Link

This block couples a sending port to a receiving input buffer over a point-to-point link. Phits offered by an upstream source cross the forward path into a receive FIFO, and a consumer drains them through a read port. The receiver compares its FIFO fill against two thresholds, an upper mark and a lower mark. It tells the sender to pause or resume by placing a single control symbol on a separate reverse channel.

The reverse channel has a configurable latency of `LAT` cycles. The sender obeys a pause within one cycle of seeing it and resumes on the cycle after a resume symbol, so some phits are always in flight when a pause is issued. The FIFO therefore keeps spare room above the upper mark to absorb them. Because the two marks are apart, the link does not toggle on every phit. Symbols are emitted only when a mark is crossed, and the reverse channel carries an idle code at all other times.

Top module: `wm_link_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `fill_level` is 0, `src_accept` is 1, `rev_sym` is idle (2'b00), `drain_valid` is 0 and `ovf_err` is 0.
- R2: A drain request made while the FIFO holds data returns the oldest phit on `drain_data`, with `drain_valid` high, one cycle later. Phits leave in the order they were accepted.
- R3: `ovf_err` goes high, and stays high until reset, if a phit reaches the FIFO while it is full. With `DEPTH >= HIGH_MARK + 2*LAT + 4` it never goes high.
- R4: The cycle after `fill_level` is at or above `HIGH_MARK` while the receiver is in its running state, `rev_sym` carries the stop code 2'b01 for exactly one cycle.
- R5: The cycle after `fill_level` is at or below `LOW_MARK` while the receiver is in its paused state, `rev_sym` carries the resume code 2'b10 for exactly one cycle.
- R6: When neither condition of R4 or R5 holds, `rev_sym` is idle (2'b00). This includes the span between the marks and any time spent beyond a mark after its symbol has already been sent.
- R7: A symbol on `rev_sym` reaches the sender `LAT` cycles later. `src_accept` falls `LAT+1` cycles after a stop symbol appears and rises `LAT+1` cycles after a resume symbol appears.
- R8: A phit is taken when `src_valid` and `src_accept` are both high at a clock edge. It is counted in `fill_level` after the following edge. With a source that always has data and no draining, the fill peaks at exactly `HIGH_MARK + LAT + 3`.
- R9: A drain request while the FIFO is empty is ignored: `drain_valid` stays low and `fill_level` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends of the link |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Upstream has a phit on `src_data` |
| src_data | input | W | Phit offered by upstream |
| src_accept | output | 1 | Sender is running; a phit offered now is taken |
| drain_en | input | 1 | Consumer asks for one phit from the FIFO |
| drain_valid | output | 1 | `drain_data` holds a phit read on the previous cycle |
| drain_data | output | W | Phit read from the FIFO |
| rev_sym | output | 2 | Symbol placed on the reverse channel: 00 idle, 01 stop, 10 resume |
| fill_level | output | $clog2(DEPTH+1) | FIFO occupancy |
| ovf_err | output | 1 | Sticky flag: a phit arrived at a full FIFO |

## Verification
The bench drives a source that always has data into a FIFO that is not being drained. It confirms that the stop symbol appears on the exact cycle after the fill reaches the upper mark, that the sender halts `LAT+1` cycles later, and that the fill peaks at exactly the in-flight bound. A design that counted the round trip wrongly would show up as a different peak or as a flagged overflow. The bench then drains the FIFO through the whole band between the marks and checks that only one resume symbol appears, at the lower mark. A design without hysteresis, or one that repeats symbols, would emit extra codes that the symbol counters catch. Every drained phit is compared against the sequence that was accepted, which exposes reordering, loss or a wrong read latency. Draining an empty FIFO must return nothing.

// File: rtl/wm_link_pkg.sv
package wm_link_pkg;

  // Reverse-channel control code
  typedef enum logic [1:0] {
    SYM_IDLE = 2'b00,
    SYM_STOP = 2'b01,
    SYM_GO   = 2'b10
  } fc_sym_e;

endpackage

// File: rtl/wm_sym_pipe.sv
// Fixed-latency reverse channel: LAT register stages, idle after reset.
module wm_sym_pipe
  import wm_link_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  fc_sym_e sym_in,
  output fc_sym_e sym_out
);

  generate
    if (LAT == 0) begin : g_wire
      assign sym_out = sym_in;
    end else begin : g_stages
      fc_sym_e stg [LAT];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < LAT; i++) stg[i] <= SYM_IDLE;
        end else begin
          stg[0] <= sym_in;
          for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
        end
      end

      assign sym_out = stg[LAT-1];
    end
  endgenerate

endmodule

// File: rtl/wm_sender.sv
// Transmit side: a run/halt state driven by received symbols, with a registered forward path.
module wm_sender
  import wm_link_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         src_valid,
  input  logic [W-1:0] src_data,
  output logic         src_accept,
  input  fc_sym_e      rev_sym,
  output logic         link_valid,
  output logic [W-1:0] link_data
);

  logic         run_q;
  logic         lvalid_q;
  logic [W-1:0] ldata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b1;
    end else if (rev_sym == SYM_STOP) begin
      run_q <= 1'b0;
    end else if (rev_sym == SYM_GO) begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvalid_q <= 1'b0;
    end else begin
      lvalid_q <= src_valid && run_q;
    end
  end

  always_ff @(posedge clk) begin
    if (src_valid && run_q) ldata_q <= src_data;
  end

  assign src_accept = run_q;
  assign link_valid = lvalid_q;
  assign link_data  = ldata_q;

  // R7: a stop symbol halts the sender by the next cycle
  a_r7_stop_halts: assert property (@(posedge clk) disable iff (rst)
    (rev_sym == SYM_STOP) |=> !src_accept);

  // R7: a resume symbol restarts the sender on the next cycle
  a_r7_go_resumes: assert property (@(posedge clk) disable iff (rst)
    (rev_sym == SYM_GO) |=> src_accept);

  // R8: nothing enters the link unless it was taken
  a_r8_only_taken: assert property (@(posedge clk) disable iff (rst)
    !(src_valid && src_accept) |=> !link_valid);

endmodule

// File: rtl/wm_rx_fifo.sv
// Receive buffer: memory without reset so that block RAM can be inferred, one-cycle registered read.
module wm_rx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic                         rd_valid,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         ovf
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          rvalid_q, ovf_q;
  logic [W-1:0]  rdata_q;
  logic          full, empty, wr_ok, rd_ok;

  assign full  = (cnt_q == FULL_N);
  assign empty = (cnt_q == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rdata_q <= mem[rd_ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      rvalid_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_ok) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      rvalid_q <= rd_ok;
      if (wr_en && full) ovf_q <= 1'b1;
    end
  end

  assign rd_valid = rvalid_q;
  assign rd_data  = rdata_q;
  assign level    = cnt_q;
  assign ovf      = ovf_q;

  // R3: the slack above the high mark must absorb every phit in flight
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  // R2: a read of a non-empty buffer returns data one cycle later
  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> rd_valid);

  // R9: draining an empty buffer with no write leaves it empty
  a_r9_empty_drain: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> (empty && !rd_valid));

endmodule

// File: rtl/wm_mark_ctrl.sv
// Receive-side watermark monitor with hysteresis; emits one symbol per crossing.
module wm_mark_ctrl
  import wm_link_pkg::*;
#(
  parameter int CW        = 6,
  parameter int HIGH_MARK = 20,
  parameter int LOW_MARK  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level,
  output fc_sym_e       sym
);

  localparam logic [CW-1:0] HI_V = CW'(HIGH_MARK);
  localparam logic [CW-1:0] LO_V = CW'(LOW_MARK);

  logic    open_q;
  fc_sym_e sym_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b1;
      sym_q  <= SYM_IDLE;
    end else if (open_q && (level >= HI_V)) begin
      open_q <= 1'b0;
      sym_q  <= SYM_STOP;
    end else if (!open_q && (level <= LO_V)) begin
      open_q <= 1'b1;
      sym_q  <= SYM_GO;
    end else begin
      sym_q  <= SYM_IDLE;
    end
  end

  assign sym = sym_q;

  // R4: stop only follows a fill at or above the high mark
  a_r4_stop_at_mark: assert property (@(posedge clk) disable iff (rst)
    (sym == SYM_STOP) |-> ($past(level) >= HI_V));

  // R5: resume only follows a fill at or below the low mark
  a_r5_go_at_mark: assert property (@(posedge clk) disable iff (rst)
    (sym == SYM_GO) |-> ($past(level) <= LO_V));

  // R6: a stop is never repeated on the following cycle
  a_r6_stop_once: assert property (@(posedge clk) disable iff (rst)
    (sym == SYM_STOP) |=> (sym != SYM_STOP));

  // R6: a resume is never repeated on the following cycle
  a_r6_go_once: assert property (@(posedge clk) disable iff (rst)
    (sym == SYM_GO) |=> (sym != SYM_GO));

endmodule

// File: rtl/wm_link_top.sv
module wm_link_top
  import wm_link_pkg::*;
#(
  parameter int W         = 16,
  parameter int DEPTH     = 32,
  parameter int HIGH_MARK = 20,
  parameter int LOW_MARK  = 8,
  parameter int LAT       = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       src_valid,
  input  logic [W-1:0]               src_data,
  output logic                       src_accept,
  input  logic                       drain_en,
  output logic                       drain_valid,
  output logic [W-1:0]               drain_data,
  output logic [1:0]                 rev_sym,
  output logic [$clog2(DEPTH+1)-1:0] fill_level,
  output logic                       ovf_err
);

  localparam int CW = $clog2(DEPTH+1);

  initial begin
    if (LOW_MARK >= HIGH_MARK || DEPTH < HIGH_MARK + 2*LAT + 4)
      $error("wm_link_top: marks or depth leave too little slack");
  end

  fc_sym_e       sym_rx, sym_tx;
  logic          lnk_valid;
  logic [W-1:0]  lnk_data;
  logic [CW-1:0] lvl;

  wm_sender #(.W(W)) u_sender (
    .clk        (clk),
    .rst        (rst),
    .src_valid  (src_valid),
    .src_data   (src_data),
    .src_accept (src_accept),
    .rev_sym    (sym_tx),
    .link_valid (lnk_valid),
    .link_data  (lnk_data)
  );

  wm_rx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (lnk_valid),
    .wr_data  (lnk_data),
    .rd_en    (drain_en),
    .rd_valid (drain_valid),
    .rd_data  (drain_data),
    .level    (lvl),
    .ovf      (ovf_err)
  );

  wm_mark_ctrl #(.CW(CW), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .level (lvl),
    .sym   (sym_rx)
  );

  wm_sym_pipe #(.LAT(LAT)) u_rev (
    .clk     (clk),
    .rst     (rst),
    .sym_in  (sym_rx),
    .sym_out (sym_tx)
  );

  assign rev_sym    = sym_rx;
  assign fill_level = lvl;

endmodule

// File: tb/wm_link_top_tb_top.sv
`timescale 1ns/1ps
module wm_link_top_tb_top;

  localparam int W = 16, DEPTH = 32, HI = 20, LO = 8, LAT = 3;
  localparam int CW = $clog2(DEPTH+1);
  localparam int PEAK = HI + LAT + 3;
  localparam real TCLK = 20.0;

  // Phase table: cycles, src_valid, drain_en, expected fill, accept, stop total, resume total
  localparam int NV = 8;
  localparam int V_N   [NV] = '{40, 40, 10, 10, 5, 20, 40, 40};
  localparam int V_SV  [NV] = '{ 1,  1,  0,  1, 0,  1,  1,  0};
  localparam int V_DR  [NV] = '{ 0,  1,  1,  0, 0,  1,  0,  1};
  localparam int V_FL  [NV] = '{PEAK, 2, 0, 9, 10, 9, PEAK, 0};
  localparam int V_AC  [NV] = '{ 0,  1,  1,  1, 1,  1,  0,  1};
  localparam int V_ST  [NV] = '{ 1,  1,  1,  1, 1,  1,  2,  2};
  localparam int V_GO  [NV] = '{ 0,  1,  1,  1, 1,  1,  1,  2};

  logic clk = 0, rst = 1;
  logic src_valid = 0, drain_en = 0;
  logic [W-1:0] src_data = '0;
  logic src_accept, drain_valid, ovf_err;
  logic [W-1:0] drain_data;
  logic [1:0] rev_sym;
  logic [CW-1:0] fill_level;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [W-1:0] tx_seq = '0, rx_seq = '0;
  int stops = 0, gos = 0, pstep = 0;
  int ev_stop = -1, ev_go = -1, ev_fall = -1, ev_rise = -1;

  always #(TCLK/2) clk = ~clk;

  wm_link_top #(.W(W), .DEPTH(DEPTH), .HIGH_MARK(HI), .LOW_MARK(LO), .LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_data(src_data),
    .src_accept(src_accept), .drain_en(drain_en), .drain_valid(drain_valid),
    .drain_data(drain_data), .rev_sym(rev_sym), .fill_level(fill_level),
    .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  endtask

  // One cycle: drive at the falling edge, observe at the next falling edge
  task automatic step(input logic sv, input logic dr);
    logic took, rd, acc_before;
    src_valid = sv;
    drain_en  = dr;
    src_data  = tx_seq;
    took = sv && src_accept;
    rd   = dr && (fill_level != '0);
    acc_before = src_accept;
    @(posedge clk);
    @(negedge clk);
    pstep++;
    if (took) tx_seq++;
    if (rd) begin
      chk(drain_valid === 1'b1, "R2 drain_valid", int'(drain_valid), 1);
      chk(drain_data === rx_seq, "R2 drain order", int'(drain_data), int'(rx_seq));
      rx_seq++;
    end else begin
      chk(drain_valid === 1'b0, "R9 no data from empty/idle drain", int'(drain_valid), 0);
    end
    if (rev_sym == 2'b01) begin stops++; ev_stop = pstep; end
    if (rev_sym == 2'b10) begin gos++;   ev_go   = pstep; end
    if (acc_before && !src_accept) ev_fall = pstep;
    if (!acc_before && src_accept) ev_rise = pstep;
    chk(int'(fill_level) <= PEAK, "R8 fill bound", int'(fill_level), PEAK);
    chk(ovf_err === 1'b0, "R3 overflow flag", int'(ovf_err), 0);
  endtask

  initial begin
    #(TCLK * 200000);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is held
    chk(fill_level == '0, "R1 fill at reset", int'(fill_level), 0);
    chk(src_accept === 1'b1, "R1 accept at reset", int'(src_accept), 1);
    chk(rev_sym == 2'b00, "R1 idle symbol at reset", int'(rev_sym), 0);
    chk(drain_valid === 1'b0, "R1 drain_valid at reset", int'(drain_valid), 0);
    chk(ovf_err === 1'b0, "R1 ovf at reset", int'(ovf_err), 0);
    rst = 0;

    for (int v = 0; v < NV; v++) begin
      pstep = 0;
      ev_stop = -1; ev_go = -1; ev_fall = -1; ev_rise = -1;
      for (int c = 0; c < V_N[v]; c++) step(V_SV[v] != 0, V_DR[v] != 0);
      chk(int'(fill_level) == V_FL[v], "R8 phase fill", int'(fill_level), V_FL[v]);
      chk(int'(src_accept) == V_AC[v], "R7 phase accept", int'(src_accept), V_AC[v]);
      chk(stops == V_ST[v], "R4 R6 stop count", stops, V_ST[v]);
      chk(gos == V_GO[v], "R5 R6 resume count", gos, V_GO[v]);
      if (v == 0) begin
        // R4: fill hits HI after edge HI+1, stop one cycle later
        chk(ev_stop == HI + 2, "R4 stop cycle", ev_stop, HI + 2);
        chk(ev_fall == HI + 2 + LAT + 1, "R7 halt delay", ev_fall, HI + 2 + LAT + 1);
      end
      if (v == 1) begin
        // R5: fill falls PEAK-LO cycles into draining, resume one cycle later
        chk(ev_go == PEAK - LO + 1, "R5 resume cycle", ev_go, PEAK - LO + 1);
        chk(ev_rise == PEAK - LO + 1 + LAT + 1, "R7 resume delay", ev_rise, PEAK - LO + 2 + LAT);
      end
    end

    // R9: drain requests on an empty buffer leave it empty
    for (int c = 0; c < 4; c++) step(1'b0, 1'b1);
    chk(fill_level == '0, "R9 empty after drain", int'(fill_level), 0);
    chk(rev_sym == 2'b00, "R6 idle when quiet", int'(rev_sym), 0);

    // R1: reset mid-stream restores the initial state
    step(1'b1, 1'b0);
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    src_valid = 0;
    @(posedge clk); @(negedge clk);
    chk(fill_level == '0, "R1 fill after reset", int'(fill_level), 0);
    chk(src_accept === 1'b1, "R1 accept after reset", int'(src_accept), 1);
    chk(drain_valid === 1'b0, "R1 drain_valid after reset", int'(drain_valid), 0);

    finish_run();
  end

endmodule